// File: doc/BRIEF.md
# External Memory Interface Controller

The controller sits between a CPU data-memory request port and three possible targets: a block of on-chip XRAM, a 1 KB FIFO RAM window that can be mapped into the data space, and an external parallel memory bus. For every request it forms a full 16-bit address, decides which target serves the access, and either completes it at once on-chip or runs an external bus cycle with address-latch, read and write strobes. When the access is finished it returns a one-cycle done pulse and, for reads, the data.

An 8-bit configuration register sets the routing mode, chooses between a multiplexed bus (address low byte and data share the same pins) and separate address and data pins, and sets how long the address latch strobe stays high and then low. An 8-bit request carries only the low address byte. The upper byte is taken either from the current address-high port latch value or from a bank register, depending on the routing mode.

Top module: `xmem_bridge`

## Requirements
- R1: After reset the configuration reads 0x03 (with the FIFO-enable input low), the request port is ready, the external read and write strobes are high (inactive) and the address latch strobe is low.
- R2: A configuration write stores bits 4:0. Bits 7 and 5 always read 0. Bit 6 reads the FIFO-enable input and cannot be written. Field layout: bit 4 selects separate pins (1) or the multiplexed bus (0), bits 3:2 are the routing mode, and bits 1:0 are the latch width field.
- R3: In routing mode 0 every access goes to XRAM, and the XRAM address is the full address modulo the XRAM size (2048 bytes by default).
- R4: In routing modes 1 and 2, addresses below the XRAM size go to XRAM and all others start an external cycle. Exactly one target is selected per accepted request.
- R5: In routing mode 3 every access starts an external cycle and XRAM is never enabled.
- R6: For an 8-bit request the upper address byte is the port-latch input in routing mode 1 and the bank-register input in every other mode. The external address bus carries the full 16-bit address for the whole external cycle.
- R7: While the FIFO-enable input is high and the routing mode is not 3, addresses 0x0400 to 0x07FF go to the FIFO RAM at offset address[9:0], and XRAM is not enabled. While the input is low, that range goes to XRAM.
- R8: A multiplexed external cycle holds the latch strobe high for W cycles and then low for W cycles before any read or write strobe, where W is the width field plus 1. The shared pins carry the address low byte, with output enable high, through both latch phases.
- R9: In separate-pin mode the latch strobe stays low and the read or write strobe starts in the first cycle after acceptance.
- R10: The read or write strobe stays low for STROBE_CYC cycles (2 by default). One recovery cycle follows, and done pulses in the next cycle. Ready is low from acceptance through recovery, and read and write strobes are never low together.
- R11: An XRAM or FIFO access is accepted in one cycle and done is high in the following cycle, with no latch, read or write strobe activity.
- R12: Read data is captured from the target on the accepting edge (on-chip) or on the last strobe cycle (external). It then stays unchanged through writes and idle time until the next read.
- R13: During an external write strobe the data pins carry the write data with output enable high. During an external read strobe output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Configuration read value |
| fifo_win_en | input | 1 | FIFO window enable, set from the FIFO side |
| port_hi | input | 8 | Address-high port latch value |
| bank_page | input | 8 | Bank register value |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = 8-bit address form |
| req_addr | input | 16 | Request address (low byte only used in 8-bit form) |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, held until next read |
| xram_en | output | 1 | XRAM access enable |
| xram_we | output | 1 | XRAM write enable |
| xram_addr | output | 11 | XRAM address |
| xram_wdata | output | 8 | XRAM write data |
| xram_rdata | input | 8 | XRAM read data, same cycle |
| fifo_en | output | 1 | FIFO RAM access enable |
| fifo_we | output | 1 | FIFO RAM write enable |
| fifo_addr | output | 10 | FIFO RAM address |
| fifo_wdata | output | 8 | FIFO RAM write data |
| fifo_rdata | input | 8 | FIFO RAM read data, same cycle |
| ext_addr | output | 16 | External address bus |
| ext_ad_out | output | 8 | External data (or multiplexed address/data) out |
| ext_ad_oe | output | 1 | Output enable of the data pins |
| ext_ad_in | input | 8 | External data in |
| ext_ale | output | 1 | Address latch strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest situation to reach is an 8-bit access whose upper byte comes from the port latch or the bank register and lands on the boundary of the FIFO window or the XRAM size. Only certain mode, enable and high-byte combinations put it there. The stimulus programs each routing mode in turn, sets the high-byte sources to values that push the formed address onto each side of 0x0400, 0x0800 and the external range, and steps the latch width field through all four values. A behavioural timeline model predicts the strobe, ready and done levels in every cycle of each external cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {TGT_XRAM, TGT_FIFO, TGT_EXT} tgt_e;

  typedef enum logic [2:0] {SQ_IDLE, SQ_ALE_HI, SQ_ALE_LO, SQ_STRB, SQ_RECOV} seq_e;

  // Upper byte source for 8-bit requests: port latch in mode 1, bank otherwise.
  function automatic logic [15:0] full_addr(input logic       short_f,
                                            input logic [15:0] a,
                                            input logic [1:0]  mode,
                                            input logic [7:0]  port_hi,
                                            input logic [7:0]  bank);
    logic [7:0] hi;
    hi = (mode == 2'd1) ? port_hi : bank;
    return short_f ? {hi, a[7:0]} : a;
  endfunction

  // Latch phase length in cycles from the 2-bit width field.
  function automatic logic [2:0] ale_cycles(input logic [1:0] fld);
    return {1'b0, fld} + 3'd1;
  endfunction

endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       fifo_win_en,
  output logic [4:0] cfg_q,
  output logic [7:0] rdata
);
  logic unused_hi;
  assign unused_hi = ^wdata[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= 5'b00011;
    else if (wr_en) cfg_q <= wdata[4:0];
  end

  assign rdata = {1'b0, fifo_win_en, 1'b0, cfg_q};
endmodule

// File: rtl/xmem_route.sv
module xmem_route
  import xmem_pkg::*;
#(
  parameter int          XRAM_AW   = 11,
  parameter int          FIFO_AW   = 10,
  parameter logic [15:0] FIFO_BASE = 16'h0400
) (
  input  logic [1:0]  mode,
  input  logic        fifo_on,
  input  logic [15:0] addr,
  output tgt_e        tgt
);
  localparam logic [16:0] XRAM_TOP = 17'(2 ** XRAM_AW);
  localparam int          WIN_HB   = 16 - FIFO_AW;
  localparam logic [WIN_HB-1:0] WIN_TAG = FIFO_BASE[15:FIFO_AW];

  logic below_top, in_win;
  assign below_top = {1'b0, addr} < XRAM_TOP;
  assign in_win    = fifo_on && (addr[15:FIFO_AW] == WIN_TAG);

  always_comb begin
    if (mode == 2'd3)      tgt = TGT_EXT;
    else if (in_win)       tgt = TGT_FIFO;
    else if (mode == 2'd0) tgt = TGT_XRAM;
    else if (below_top)    tgt = TGT_XRAM;
    else                   tgt = TGT_EXT;
  end
endmodule

// File: rtl/xmem_ext_seq.sv
module xmem_ext_seq
  import xmem_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wr,
  input  logic        mux,
  input  logic [1:0]  ale_fld,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic        busy,
  output logic        ale,
  output logic        rd_n,
  output logic        wr_n,
  output logic [15:0] addr_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  output logic        cap,
  output logic        fin,
  output logic        cyc_mux
);
  localparam int CMAX = (STROBE_CYC > 4) ? STROBE_CYC : 4;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] S_LOAD = CW'(STROBE_CYC - 1);

  seq_e          state;
  logic [CW-1:0] cnt;
  logic [2:0]    w_q;
  logic          wr_q;
  logic [7:0]    wdata_q;
  logic          cnt_zero, in_ale;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      w_q     <= 3'd1;
      wr_q    <= 1'b0;
      cyc_mux <= 1'b0;
      addr_o  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      state   <= mux ? SQ_ALE_HI : SQ_STRB;
      cnt     <= mux ? CW'(ale_cycles(ale_fld) - 3'd1) : S_LOAD;
      w_q     <= ale_cycles(ale_fld);
      wr_q    <= wr;
      cyc_mux <= mux;
      addr_o  <= addr;
      wdata_q <= wdata;
    end else begin
      case (state)
        SQ_ALE_HI: if (cnt_zero) begin
          state <= SQ_ALE_LO;
          cnt   <= CW'(w_q - 3'd1);
        end else cnt <= cnt - 1'b1;
        SQ_ALE_LO: if (cnt_zero) begin
          state <= SQ_STRB;
          cnt   <= S_LOAD;
        end else cnt <= cnt - 1'b1;
        SQ_STRB: if (cnt_zero) state <= SQ_RECOV;
                 else cnt <= cnt - 1'b1;
        SQ_RECOV: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign in_ale = (state == SQ_ALE_HI) || (state == SQ_ALE_LO);
  assign busy   = (state != SQ_IDLE);
  assign ale    = (state == SQ_ALE_HI);
  assign rd_n   = !((state == SQ_STRB) && !wr_q);
  assign wr_n   = !((state == SQ_STRB) && wr_q);
  assign ad_o   = in_ale ? addr_o[7:0] : wdata_q;
  assign ad_oe  = (in_ale && cyc_mux) || ((state == SQ_STRB) && wr_q);
  assign cap    = (state == SQ_STRB) && cnt_zero && !wr_q;
  assign fin    = (state == SQ_RECOV);
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
  import xmem_pkg::*;
#(
  parameter int          XRAM_AW    = 11,
  parameter int          FIFO_AW    = 10,
  parameter logic [15:0] FIFO_BASE  = 16'h0400,
  parameter int          STROBE_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic               fifo_win_en,
  input  logic [7:0]         port_hi,
  input  logic [7:0]         bank_page,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_short,
  input  logic [15:0]        req_addr,
  input  logic [7:0]         req_wdata,
  output logic               req_ready,
  output logic               rsp_done,
  output logic [7:0]         rsp_rdata,
  output logic               xram_en,
  output logic               xram_we,
  output logic [XRAM_AW-1:0] xram_addr,
  output logic [7:0]         xram_wdata,
  input  logic [7:0]         xram_rdata,
  output logic               fifo_en,
  output logic               fifo_we,
  output logic [FIFO_AW-1:0] fifo_addr,
  output logic [7:0]         fifo_wdata,
  input  logic [7:0]         fifo_rdata,
  output logic [15:0]        ext_addr,
  output logic [7:0]         ext_ad_out,
  output logic               ext_ad_oe,
  input  logic [7:0]         ext_ad_in,
  output logic               ext_ale,
  output logic               ext_rd_n,
  output logic               ext_wr_n
);
  logic [4:0]  cfg_q;
  logic [1:0]  mode;
  logic        mux_sel;
  logic [15:0] addr_full;
  tgt_e        tgt;
  logic        busy, fire, ext_start_w, onchip_fire, onchip_rd;
  logic        seq_cap, seq_fin, seq_mux, cap_evt_w;

  xmem_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
    .fifo_win_en(fifo_win_en), .cfg_q(cfg_q), .rdata(cfg_rdata)
  );

  assign mode      = cfg_q[3:2];
  assign mux_sel   = !cfg_q[4];
  assign addr_full = full_addr(req_short, req_addr, mode, port_hi, bank_page);

  xmem_route #(.XRAM_AW(XRAM_AW), .FIFO_AW(FIFO_AW), .FIFO_BASE(FIFO_BASE)) u_route (
    .mode(mode), .fifo_on(fifo_win_en), .addr(addr_full), .tgt(tgt)
  );

  assign req_ready   = !busy;
  assign fire        = req_valid && req_ready;
  assign ext_start_w = fire && (tgt == TGT_EXT);
  assign onchip_fire = fire && (tgt != TGT_EXT);
  assign onchip_rd   = onchip_fire && !req_write;
  assign cap_evt_w   = onchip_rd || seq_cap;

  assign xram_en    = fire && (tgt == TGT_XRAM);
  assign xram_we    = req_write;
  assign xram_addr  = addr_full[XRAM_AW-1:0];
  assign xram_wdata = req_wdata;
  assign fifo_en    = fire && (tgt == TGT_FIFO);
  assign fifo_we    = req_write;
  assign fifo_addr  = addr_full[FIFO_AW-1:0];
  assign fifo_wdata = req_wdata;

  xmem_ext_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ext_start_w), .wr(req_write), .mux(mux_sel),
    .ale_fld(cfg_q[1:0]), .addr(addr_full), .wdata(req_wdata),
    .busy(busy), .ale(ext_ale), .rd_n(ext_rd_n), .wr_n(ext_wr_n), .addr_o(ext_addr),
    .ad_o(ext_ad_out), .ad_oe(ext_ad_oe), .cap(seq_cap), .fin(seq_fin), .cyc_mux(seq_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= onchip_fire || seq_fin;
      if (onchip_rd)    rsp_rdata <= (tgt == TGT_FIFO) ? fifo_rdata : xram_rdata;
      else if (seq_cap) rsp_rdata <= ext_ad_in;
    end
  end
endmodule

// File: rtl/xmem_bridge_chk.sv
module xmem_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       xram_en,
  input logic       fifo_en,
  input logic       ext_start,
  input logic       ext_ale,
  input logic       ext_rd_n,
  input logic       ext_wr_n,
  input logic       seq_mux,
  input logic       req_ready,
  input logic [7:0] rsp_rdata,
  input logic       cap_evt
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xram_en, fifo_en, ext_start})); // R4
  AST_MODE3_NO_XRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !xram_en); // R5
  AST_ALE_ONLY_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |-> seq_mux); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n)); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n || ext_ale) |-> !req_ready); // R10
  AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (xram_en || fifo_en) |-> (ext_rd_n && ext_wr_n && !ext_ale)); // R11
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> $past(cap_evt)); // R12
endmodule

bind xmem_bridge xmem_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .xram_en(xram_en), .fifo_en(fifo_en),
  .ext_start(ext_start_w), .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
  .seq_mux(seq_mux), .req_ready(req_ready), .rsp_rdata(rsp_rdata), .cap_evt(cap_evt_w)
);

// File: tb/xmem_bridge_tb_top.sv
`timescale 1ns/1ps
module xmem_bridge_tb_top;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic fifo_win_en = 1'b0;
  logic [7:0] port_hi = '0, bank_page = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_short = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_done;
  logic [7:0] rsp_rdata;
  logic xram_en, xram_we, fifo_en, fifo_we;
  logic [10:0] xram_addr;
  logic [9:0] fifo_addr;
  logic [7:0] xram_wdata, fifo_wdata, xram_rdata, fifo_rdata;
  logic [15:0] ext_addr;
  logic [7:0] ext_ad_out, ext_ad_in;
  logic ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  assign xram_rdata = xram_addr[7:0] + 8'h21;
  assign fifo_rdata = fifo_addr[7:0] ^ 8'h99;
  assign ext_ad_in  = ext_addr[7:0] ^ 8'h3C;

  xmem_bridge dut_i (.*);

  // bench copy of the configuration
  int tb_mode = 0, tb_w = 4;
  bit tb_sep = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural timeline model ----------------
  bit m_active = 0, m_ext = 0, m_mux = 0, m_wr = 0;
  int m_t = 0, m_w = 1;

  function automatic int pre_len();
    return m_mux ? 2 * m_w : 0;
  endfunction
  function automatic bit exp_ready();
    return !(m_active && m_ext && m_t <= pre_len() + S);
  endfunction

  function automatic int exp_target(input bit sh, input logic [15:0] a, output logic [15:0] f);
    int hi;
    hi = (tb_mode == 1) ? port_hi : bank_page;
    f = sh ? 16'((hi << 8) | a[7:0]) : a;
    if (tb_mode == 3) return 2;
    if (fifo_win_en && f >= 16'h0400 && f <= 16'h07FF) return 1;
    if (tb_mode == 0) return 0;
    return (f < 16'd2048) ? 0 : 2;
  endfunction

  logic [15:0] tmp_f;
  always @(posedge clk) begin
    if (!rst_n) m_active = 0;
    else if (req_valid && exp_ready()) begin
      m_active = 1; m_t = 0; m_wr = req_write;
      m_ext = (exp_target(req_short, req_addr, tmp_f) == 2);
      m_mux = !tb_sep; m_w = tb_w;
    end else if (m_active) m_t++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ale, e_strb, e_done;
      int done_t;
      done_t = m_ext ? pre_len() + S + 1 : 0;
      e_done = m_active && m_t == done_t;
      e_ale  = m_active && m_ext && m_mux && m_t < m_w;
      e_strb = m_active && m_ext && m_t >= pre_len() && m_t < pre_len() + S;
      chk(req_ready == exp_ready(), "R10", "ready", req_ready, exp_ready());
      chk(rsp_done == e_done, "R10/R11", "done", rsp_done, e_done);
      chk(ext_ale == e_ale, "R8/R9", "ale", ext_ale, e_ale);
      chk(ext_rd_n == !(e_strb && !m_wr), "R10", "rd_n", ext_rd_n, !(e_strb && !m_wr));
      chk(ext_wr_n == !(e_strb && m_wr), "R10", "wr_n", ext_wr_n, !(e_strb && m_wr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 0;
    tb_sep = v[4]; tb_mode = v[3:2]; tb_w = v[1:0] + 1;
  endtask

  task automatic do_req(input string tag, input bit wr, input bit sh,
                        input logic [15:0] a, input logic [7:0] wd);
    logic [15:0] f;
    int tg, n;
    logic [7:0] exp_rd;
    tg = exp_target(sh, a, f);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_short = sh; req_addr = a; req_wdata = wd;
    #1;
    chk(xram_en == (tg == 0), tag, "xram_en", xram_en, tg == 0);
    chk(fifo_en == (tg == 1), tag, "fifo_en", fifo_en, tg == 1);
    if (tg == 0) chk(xram_addr == f[10:0], tag, "xram_addr", xram_addr, f[10:0]);
    if (tg == 1) chk(fifo_addr == f[9:0], tag, "fifo_addr", fifo_addr, f[9:0]);
    exp_rd = (tg == 0) ? f[7:0] + 8'h21 : (tg == 1) ? f[7:0] ^ 8'h99 : f[7:0] ^ 8'h3C;
    @(negedge clk);
    req_valid = 0;
    if (tg == 2) begin
      chk(ext_addr == f, tag, "ext_addr", ext_addr, f);
      if (!tb_sep) chk(ext_ad_out == f[7:0] && ext_ad_oe, "R8", "addr on shared pins",
                       {ext_ad_oe, ext_ad_out}, {1'b1, f[7:0]});
    end
    n = 0;
    while (!rsp_done && n < 40) begin
      if (!ext_wr_n) chk(ext_ad_out == wd && ext_ad_oe, "R13", "write data",
                         {ext_ad_oe, ext_ad_out}, {1'b1, wd});
      if (!ext_rd_n) chk(!ext_ad_oe, "R13", "oe in read", ext_ad_oe, 0);
      @(negedge clk); n++;
    end
    chk(rsp_done, tag, "done reached", rsp_done, 1);
    if (!wr) chk(rsp_rdata == exp_rd, "R12", "read data", rsp_rdata, exp_rd);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 8'h03, "R1", "cfg reset", cfg_rdata, 8'h03);
    chk(req_ready && ext_rd_n && ext_wr_n && !ext_ale, "R1", "idle bus",
        {req_ready, ext_rd_n, ext_wr_n, ext_ale}, 4'b1110);

    set_cfg(8'hFF);
    chk(cfg_rdata == 8'h1F, "R2", "cfg masked", cfg_rdata, 8'h1F);
    fifo_win_en = 1; #1;
    chk(cfg_rdata == 8'h5F, "R2", "cfg bit6 input", cfg_rdata, 8'h5F);
    fifo_win_en = 0;

    // mode 0: aliasing
    set_cfg(8'h00);
    do_req("R3", 0, 0, 16'hF234, 8'h00);
    do_req("R3", 1, 0, 16'h9ABC, 8'h77);
    do_req("R11", 0, 0, 16'h0005, 8'h00);

    // mode 1, separate pins
    set_cfg(8'h14);
    do_req("R4", 0, 0, 16'h07FF, 8'h00);
    do_req("R9", 0, 0, 16'h0800, 8'h00);
    port_hi = 8'hA0; bank_page = 8'h01;
    do_req("R6", 0, 1, 16'h0055, 8'h00);
    do_req("R13", 1, 0, 16'h4321, 8'h5E);

    // mode 2, multiplexed, every latch width
    for (int w = 0; w < 4; w++) begin
      set_cfg(8'h08 | 8'(w));
      bank_page = 8'hC3;
      do_req("R8", 1, 1, 16'h0066, 8'hA5);
      do_req("R8", 0, 1, 16'h0011, 8'h00);
    end
    bank_page = 8'h03;
    do_req("R6", 0, 1, 16'h00FE, 8'h00);

    // mode 3: all external even low addresses
    set_cfg(8'h0C);
    do_req("R5", 0, 0, 16'h0010, 8'h00);
    fifo_win_en = 1;
    do_req("R5", 0, 0, 16'h0500, 8'h00);

    // FIFO window
    set_cfg(8'h04);
    do_req("R7", 0, 0, 16'h0500, 8'h00);
    bank_page = 8'h07;
    do_req("R7", 1, 1, 16'h00FF, 8'h3D);
    do_req("R7", 0, 0, 16'h0800, 8'h00);
    do_req("R7", 0, 0, 16'h03FF, 8'h00);
    fifo_win_en = 0;
    do_req("R7", 0, 0, 16'h0500, 8'h00);

    // read data held over a write and idle time
    set_cfg(8'h0D);
    do_req("R12", 0, 0, 16'h2468, 8'h00);
    held = rsp_rdata;
    do_req("R12", 1, 0, 16'h2000, 8'h11);
    repeat (3) @(negedge clk);
    chk(rsp_rdata == held, "R12", "held after write", rsp_rdata, held);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule